// File: doc/BRIEF.md
# Next-PC Selection Unit

This block works out which address a single-cycle 32-bit processor fetches from next. It takes the current program counter, a 2-bit selector, the 16-bit relative offset and the 26-bit absolute index from the instruction word, a register operand for indirect jumps, and a branch condition from the ALU. From these it forms the sequential successor, a relative branch target, a region-absolute jump target and a register-indirect target. The selector picks one of them.

The incremented counter is also exported on its own output. The register file writes it as the return address when a call instruction links. The block contains no state. The program-counter register loads `next_pc` on its own clock edge, so the whole computation must settle within one cycle.

Top module: `nextpc_sel`

## Requirements
- R1: With `sel` = 2'b00 (sequential), `next_pc` equals `cur_pc` + 4 modulo 2^32, including wrap from 32'hFFFF_FFFC to 0.
- R2: `pc_inc` always equals `cur_pc` + 4 modulo 2^32, whatever the selector and other inputs.
- R3: With `sel` = 2'b01 (relative branch) and `take` = 1, `next_pc` equals `cur_pc` + 4 plus the 16-bit `rel_off` sign-extended and shifted left by 2, for both forward (bit 15 = 0) and backward (bit 15 = 1) offsets, modulo 2^32.
- R4: With `sel` = 2'b01 and `take` = 0, `next_pc` equals `cur_pc` + 4.
- R5: With `sel` = 2'b10 (call), `next_pc` is bits 31..28 of `cur_pc` + 4, then the 26-bit `abs_idx`, then two zero bits, with `abs_idx` bit 0 at `next_pc` bit 2.
- R6: With `sel` = 2'b11 (indirect), `next_pc` equals `reg_tgt` bit for bit, including its two low bits.
- R7: For selectors other than 2'b01, `take` has no effect on `next_pc`. `rel_off` matters only for 2'b01, `abs_idx` only for 2'b10, and `reg_tgt` only for 2'b11.
- R8: The unit is combinational. Both outputs reflect a new set of inputs in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cur_pc | input | 32 | Address of the instruction now executing |
| sel | input | 2 | Target selector: 00 sequential, 01 relative branch, 10 call, 11 indirect |
| rel_off | input | 16 | Signed word offset for relative branches |
| abs_idx | input | 26 | Word index within the current 256 MB region for calls |
| reg_tgt | input | 32 | Register operand for indirect jumps |
| take | input | 1 | Branch condition (operands compared equal) |
| next_pc | output | 32 | Address to fetch next |
| pc_inc | output | 32 | Current address plus 4, used as the link value |

## Verification
Both outputs are due zero cycles after the stimulus, because no register lies between any input and either output. The bench changes all inputs together on the falling clock edge and samples one nanosecond later, well before the next rising edge. Every sample therefore sees the settled combinational result for exactly the vector just applied. Each vector is checked on its own, so no result depends on a previous one.

// File: rtl/npc_pkg.sv
package npc_pkg;

   // Selector encoding; values are fixed by the instruction decoder
   typedef enum logic [1:0] {
      NPC_SEQ  = 2'b00,
      NPC_BR   = 2'b01,
      NPC_CALL = 2'b10,
      NPC_IND  = 2'b11
   } npc_sel_t;

   // Adder organisation for the relative target
   localparam int BR_CHAINED  = 0;  // add offset onto the incremented PC
   localparam int BR_PARALLEL = 1;  // add (offset + step) onto the raw PC

endpackage

// File: rtl/npc_incr.sv
module npc_incr #(
   parameter int ADDR_W = 32,
   parameter int STEP   = 4
) (
   input  logic [ADDR_W-1:0] pc_in,
   output logic [ADDR_W-1:0] pc_step
);

   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

   if (STEP < 1) begin : g_bad_step
      $error("npc_incr: STEP must be positive");
   end

   always_comb begin
      pc_step = pc_in + STEP_V;
   end

endmodule

// File: rtl/npc_rel_tgt.sv
module npc_rel_tgt #(
   parameter int ADDR_W     = 32,
   parameter int OFF_W      = 16,
   parameter int ALIGN_BITS = 2,
   parameter int EXTRA      = 0
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [OFF_W-1:0]  off,
   output logic [ADDR_W-1:0] target
);

   localparam int EXT_W = ADDR_W - OFF_W - ALIGN_BITS;
   localparam logic [ADDR_W-1:0] EXTRA_V = ADDR_W'(EXTRA);

   if (EXT_W < 0) begin : g_bad_widths
      $error("npc_rel_tgt: offset plus alignment exceeds address width");
   end

   logic [ADDR_W-1:0] disp;

   // sign-extend and scale to a byte displacement
   if (EXT_W == 0) begin : g_no_ext
      if (ALIGN_BITS == 0) begin : g_no_align
         assign disp = off;
      end else begin : g_align
         assign disp = {off, {ALIGN_BITS{1'b0}}};
      end
   end else begin : g_ext
      if (ALIGN_BITS == 0) begin : g_no_align
         assign disp = {{EXT_W{off[OFF_W-1]}}, off};
      end else begin : g_align
         assign disp = {{EXT_W{off[OFF_W-1]}}, off, {ALIGN_BITS{1'b0}}};
      end
   end

   // EXTRA folds the sequential step in when base is the raw PC
   logic [ADDR_W-1:0] bias;
   assign bias = disp + EXTRA_V;

   always_comb begin
      target = base + bias;
   end

endmodule

// File: rtl/npc_call_tgt.sv
module npc_call_tgt #(
   parameter int ADDR_W     = 32,
   parameter int IDX_W      = 26,
   parameter int ALIGN_BITS = 2
) (
   input  logic [ADDR_W-IDX_W-ALIGN_BITS-1:0] region,
   input  logic [IDX_W-1:0]                   idx,
   output logic [ADDR_W-1:0]                  target
);

   localparam int REGION_W = ADDR_W - IDX_W - ALIGN_BITS;

   if (REGION_W < 1) begin : g_bad_widths
      $error("npc_call_tgt: no region bits left above the index");
   end

   if (ALIGN_BITS == 0) begin : g_no_align
      assign target = {region, idx};
   end else begin : g_align
      assign target = {region, idx, {ALIGN_BITS{1'b0}}};
   end

endmodule

// File: rtl/npc_out_mux.sv
module npc_out_mux
   import npc_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  npc_sel_t          sel,
   input  logic              take,
   input  logic [ADDR_W-1:0] seq_addr,
   input  logic [ADDR_W-1:0] rel_addr,
   input  logic [ADDR_W-1:0] call_addr,
   input  logic [ADDR_W-1:0] ind_addr,
   output logic [ADDR_W-1:0] chosen
);

   always_comb begin
      unique case (sel)
         NPC_SEQ:  chosen = seq_addr;
         NPC_BR:   chosen = take ? rel_addr : seq_addr;
         NPC_CALL: chosen = call_addr;
         NPC_IND:  chosen = ind_addr;
         default:  chosen = seq_addr;
      endcase
   end

endmodule

// File: rtl/nextpc_sel.sv
module nextpc_sel
   import npc_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int OFF_W    = 16,
   parameter int IDX_W    = 26,
   parameter int STEP     = 4,
   parameter int BR_STYLE = BR_CHAINED
) (
   input  logic [ADDR_W-1:0] cur_pc,
   input  logic [1:0]        sel,
   input  logic [OFF_W-1:0]  rel_off,
   input  logic [IDX_W-1:0]  abs_idx,
   input  logic [ADDR_W-1:0] reg_tgt,
   input  logic              take,
   output logic [ADDR_W-1:0] next_pc,
   output logic [ADDR_W-1:0] pc_inc
);

   localparam int ALIGN_BITS = $clog2(STEP);
   localparam int REGION_W   = ADDR_W - IDX_W - ALIGN_BITS;

   if ((1 << ALIGN_BITS) != STEP) begin : g_bad_step
      $error("nextpc_sel: STEP must be a power of two");
   end
   if (REGION_W < 1) begin : g_bad_idx
      $error("nextpc_sel: IDX_W leaves no region bits");
   end
   if (OFF_W + ALIGN_BITS > ADDR_W) begin : g_bad_off
      $error("nextpc_sel: OFF_W too wide for ADDR_W");
   end
   if (BR_STYLE != BR_CHAINED && BR_STYLE != BR_PARALLEL) begin : g_bad_style
      $error("nextpc_sel: unknown BR_STYLE");
   end

   logic [ADDR_W-1:0] seq_a;
   logic [ADDR_W-1:0] rel_a;
   logic [ADDR_W-1:0] call_a;

   npc_incr #(.ADDR_W(ADDR_W), .STEP(STEP)) u_incr (
      .pc_in   (cur_pc),
      .pc_step (seq_a)
   );

   if (BR_STYLE == BR_CHAINED) begin : g_rel_chained
      npc_rel_tgt #(
         .ADDR_W(ADDR_W), .OFF_W(OFF_W), .ALIGN_BITS(ALIGN_BITS), .EXTRA(0)
      ) u_rel (
         .base   (seq_a),
         .off    (rel_off),
         .target (rel_a)
      );
   end else begin : g_rel_parallel
      npc_rel_tgt #(
         .ADDR_W(ADDR_W), .OFF_W(OFF_W), .ALIGN_BITS(ALIGN_BITS), .EXTRA(STEP)
      ) u_rel (
         .base   (cur_pc),
         .off    (rel_off),
         .target (rel_a)
      );
   end

   npc_call_tgt #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN_BITS(ALIGN_BITS)
   ) u_call (
      .region (seq_a[ADDR_W-1 -: REGION_W]),
      .idx    (abs_idx),
      .target (call_a)
   );

   npc_out_mux #(.ADDR_W(ADDR_W)) u_mux (
      .sel       (npc_sel_t'(sel)),
      .take      (take),
      .seq_addr  (seq_a),
      .rel_addr  (rel_a),
      .call_addr (call_a),
      .ind_addr  (reg_tgt),
      .chosen    (next_pc)
   );

   assign pc_inc = seq_a;

endmodule

// File: rtl/nextpc_sel_chk.sv
module nextpc_sel_chk #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 16,
   parameter int IDX_W  = 26,
   parameter int STEP   = 4
) (
   input logic [ADDR_W-1:0] cur_pc,
   input logic [1:0]        sel,
   input logic [OFF_W-1:0]  rel_off,
   input logic [IDX_W-1:0]  abs_idx,
   input logic [ADDR_W-1:0] reg_tgt,
   input logic              take,
   input logic [ADDR_W-1:0] next_pc,
   input logic [ADDR_W-1:0] pc_inc
);

   localparam int AB = $clog2(STEP);
   localparam int RW = ADDR_W - IDX_W - AB;

   logic [ADDR_W-1:0] gap;
   logic [ADDR_W-1:0] disp;
   assign gap  = pc_inc - cur_pc;
   assign disp = ADDR_W'($signed(rel_off)) << AB;

   always_comb begin
      p_step_r2: assert (gap == ADDR_W'(STEP))
         else $error("pc_inc is not cur_pc + step");
      if (sel == 2'b00) begin
         p_seq_r1: assert (next_pc == pc_inc)
            else $error("sequential select did not follow pc_inc");
      end
      if (sel == 2'b01 && take) begin
         p_rel_taken_r3: assert (next_pc - pc_inc == disp)
            else $error("taken branch displacement wrong");
      end
      if (sel == 2'b01 && !take) begin
         p_rel_fall_r4: assert (next_pc == pc_inc)
            else $error("untaken branch did not fall through");
      end
      if (sel == 2'b10) begin
         p_call_r5: assert (next_pc[ADDR_W-1 -: RW] == pc_inc[ADDR_W-1 -: RW]
                            && next_pc[AB +: IDX_W] == abs_idx
                            && next_pc[AB-1:0] == '0)
            else $error("call target malformed");
      end
      if (sel == 2'b11) begin
         p_ind_r6: assert (next_pc == reg_tgt)
            else $error("indirect target not passed through");
      end
   end

endmodule

bind nextpc_sel nextpc_sel_chk #(
   .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .STEP(STEP)
) u_chk (
   .cur_pc  (cur_pc),
   .sel     (sel),
   .rel_off (rel_off),
   .abs_idx (abs_idx),
   .reg_tgt (reg_tgt),
   .take    (take),
   .next_pc (next_pc),
   .pc_inc  (pc_inc)
);

// File: tb/nextpc_sel_test.sv
`timescale 1ns/1ps
module nextpc_sel_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cur_pc = '0;
   logic [1:0]  sel = '0;
   logic [15:0] rel_off = '0;
   logic [25:0] abs_idx = '0;
   logic [31:0] reg_tgt = '0;
   logic        take = 1'b0;
   logic [31:0] next_pc;
   logic [31:0] pc_inc;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   nextpc_sel uut (
      .cur_pc(cur_pc), .sel(sel), .rel_off(rel_off), .abs_idx(abs_idx),
      .reg_tgt(reg_tgt), .take(take), .next_pc(next_pc), .pc_inc(pc_inc)
   );

   function automatic logic [31:0] f_inc(input logic [31:0] p);
      return p + 32'd4;
   endfunction

   function automatic logic [31:0] f_next(input logic [31:0] p, input logic [1:0] s,
                                          input logic [15:0] o, input logic [25:0] x,
                                          input logic [31:0] r, input logic t);
      logic [31:0] q;
      q = p + 32'd4;
      case (s)
         2'b00:   return q;
         2'b01:   return t ? q + {{14{o[15]}}, o, 2'b00} : q;
         2'b10:   return {q[31:28], x, 2'b00};
         default: return r;
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h (pc=%h sel=%b off=%h idx=%h reg=%h take=%b)",
                  req, act, exp, cur_pc, sel, rel_off, abs_idx, reg_tgt, take);
      end
   endtask

   // drive on the falling edge, sample 1 ns later (zero-cycle latency)
   task automatic apply(input logic [31:0] p, input logic [1:0] s, input logic [15:0] o,
                        input logic [25:0] x, input logic [31:0] r, input logic t);
      @(negedge clk);
      cur_pc = p; sel = s; rel_off = o; abs_idx = x; reg_tgt = r; take = t;
      #1;
   endtask

   function automatic string tag(input logic [1:0] s, input logic t);
      case (s)
         2'b00:   return "R1";
         2'b01:   return t ? "R3" : "R4";
         2'b10:   return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic run_vec(input logic [31:0] p, input logic [1:0] s, input logic [15:0] o,
                          input logic [25:0] x, input logic [31:0] r, input logic t);
      apply(p, s, o, x, r, t);
      check(tag(s, t), next_pc, f_next(p, s, o, x, r, t));
      check("R2", pc_inc, f_inc(p));
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // reset-time inputs all zero: R1/R2 idle values, same cycle (R8)
      #1;
      check("R1", next_pc, 32'h0000_0004);
      check("R2", pc_inc, 32'h0000_0004);

      // R1 wrap at top of address space
      run_vec(32'hFFFF_FFFC, 2'b00, 16'h0, 26'h0, 32'h0, 1'b0);
      check("R1", next_pc, 32'h0000_0000);
      // R3 forward and backward extremes
      run_vec(32'h0040_0000, 2'b01, 16'h7FFF, 26'h0, 32'h0, 1'b1);
      check("R3", next_pc, 32'h0042_0000);
      run_vec(32'h0040_0000, 2'b01, 16'h8000, 26'h0, 32'h0, 1'b1);
      check("R3", next_pc, 32'h003E_0004);
      run_vec(32'h0000_0010, 2'b01, 16'hFFFF, 26'h0, 32'h0, 1'b1);
      check("R3", next_pc, 32'h0000_0010);
      run_vec(32'h0000_0000, 2'b01, 16'hFFF0, 26'h0, 32'h0, 1'b1);
      check("R3", next_pc, 32'hFFFF_FFC4);
      // R4 not taken with a large offset present
      run_vec(32'h0040_0000, 2'b01, 16'h7FFF, 26'h0, 32'h0, 1'b0);
      check("R4", next_pc, 32'h0040_0004);
      // R5 region taken from PC+4 when it crosses a region boundary
      run_vec(32'h0FFF_FFFC, 2'b10, 26'h3FF_FFFF, 26'h0000001, 32'h0, 1'b0);
      check("R5", next_pc, 32'h1000_0004);
      run_vec(32'hA000_1234, 2'b10, 16'h0, 26'h3FF_FFFF, 32'h0, 1'b0);
      check("R5", next_pc, 32'hAFFF_FFFC);
      // R6 unaligned value passes unchanged
      run_vec(32'h0000_1000, 2'b11, 16'h0, 26'h0, 32'h1234_5677, 1'b0);
      check("R6", next_pc, 32'h1234_5677);

      // R7: toggle inputs the chosen selector does not use
      for (int s = 0; s < 4; s++) begin
         logic [31:0] ref_v;
         apply(32'h0040_1000, 2'(s), 16'h0123, 26'h0ABCDEF, 32'hDEAD_BEE0, 1'b0);
         ref_v = next_pc;
         if (s != 1) begin
            apply(32'h0040_1000, 2'(s), (s == 1) ? 16'h0123 : 16'hF00D,
                  (s == 2) ? 26'h0ABCDEF : 26'h1234567,
                  (s == 3) ? 32'hDEAD_BEE0 : 32'h5555_AAAA, 1'b1);
            check("R7", next_pc, ref_v);
         end else begin
            apply(32'h0040_1000, 2'(s), 16'h0123, 26'h1234567, 32'h5555_AAAA, 1'b0);
            check("R7", next_pc, ref_v);
         end
      end

      // constrained random mix, fixed seed
      void'($urandom(32'h1F2E_3D4C));
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] p;
         logic [1:0]  s;
         p = {$urandom()} & 32'hFFFF_FFFC;
         if (i % 16 == 0) p = 32'hFFFF_FFFC - {$urandom_range(0, 3), 2'b00};
         s = 2'($urandom_range(0, 3));
         run_vec(p, s, 16'($urandom()), 26'($urandom()), $urandom(), 1'($urandom()));
      end

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule